// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a synthesizable model of a synchronous burst static RAM. Each word is 36 bits wide and is made of four 9-bit byte lanes; the depth is set by a parameter. Every control input is sampled on the rising clock edge: the address, the three select inputs, the two burst-start strobes, the burst step input and the write controls. From these the block performs single accesses, four-beat bursts and suspended bursts, reads and writes, and per-lane write masking.

The burst offset is not generated inside the block. The core reports the low two bits of the address it last accessed on `burst_off_o`. An external counter turns that value into the next offset, in linear or interleaved order, and returns it on `next_off_i`. A run-time mode input selects how read data is returned. In flow-through mode the data comes straight from the array register. In registered mode it passes through one more output stage.

The read-data enable uses dual-cycle-deselect timing, so a deselect moves through the output stages exactly as a read does. An asynchronous active-low output enable can force the outputs off. Data in, data out and the drive enable are separate ports, and no bidirectional pad is modelled.

Top module: `sbs_burst_sram`

## Requirements
- R1: The device counts as selected only when `sel_n_i`=0, `sel_hi_i`=1 and `sel_lo_n_i`=0. A cycle with either strobe low while the device is not selected is a deselect. A deselect writes nothing and ends the active burst. After it, cycles with both strobes high do nothing.
- R2: A cycle with either strobe low while the device is selected loads `addr_i` as the access address. When `strb_a_n_i`=0, the cycle is always a read and the array is not written, whatever the write controls say.
- R3: A start with `strb_a_n_i`=1 and `strb_b_n_i`=0 is a write if the write decode of R5 gives a non-empty lane mask. Otherwise it is a read.
- R4: When both strobes are high and a burst is active, `step_n_i`=0 replaces the low two address bits with `next_off_i` and keeps the upper bits. `step_n_i`=1 reuses the same address. `burst_off_o` shows the low two bits of the most recently accessed address and is 0 after reset.
- R5: Write decode. `all_wr_n_i`=0 writes all four lanes. Otherwise `byte_wr_n_i`=0 writes exactly the lanes k whose `lane_wr_n_i[k]`=0, where lane k is bits 9k+8..9k. With both inputs high the cycle is a read.
- R6: With `reg_mode_i`=0 (flow-through), read data for a command sampled at edge N appears on `rdata_o` between edges N and N+1. With `reg_mode_i`=1 (registered), it appears one cycle later, between edges N+1 and N+2.
- R7: The drive enable `rdata_en_o` follows the same latency as the data. A read turns it on. A deselect, a write or an idle cycle turns it off, with the same delay, so in registered mode the outputs stay on for the full cycle after a deselect.
- R8: During a cycle whose sampled inputs form a write command, `rdata_en_o` is 0.
- R9: `out_en_n_i`=1 forces `rdata_en_o` to 0 at once, with no clock edge needed. `out_en_n_i`=0 only lets through a drive that a read has already set up.
- R10: A read issued with `out_en_n_i`=1 (a dummy read) still counts as a read. It advances the burst, and a following continue cycle reads the next address.
- R11: Whenever `rdata_en_o` is 0, `rdata_o` is all zeros.
- R12: Synchronous reset `rst`=1 clears the output stages and the burst state, so `rdata_en_o`=0 and `burst_off_o`=0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | External access address |
| sel_n_i | input | 1 | Select, active low |
| sel_hi_i | input | 1 | Select, active high |
| sel_lo_n_i | input | 1 | Select, active low |
| strb_a_n_i | input | 1 | Burst-start strobe that always reads, active low |
| strb_b_n_i | input | 1 | Burst-start strobe that reads or writes, active low |
| step_n_i | input | 1 | Burst step: 0 advances, 1 suspends |
| all_wr_n_i | input | 1 | Write all lanes, active low |
| byte_wr_n_i | input | 1 | Per-lane write qualifier, active low |
| lane_wr_n_i | input | LANES | Per-lane write selects, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| next_off_i | input | 2 | Next burst offset from the external counter |
| reg_mode_i | input | 1 | 1 = registered read data, 0 = flow-through |
| out_en_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_en_o | output | 1 | Read-data drive enable |
| burst_off_o | output | 2 | Low address bits of the last access |

## Verification
On every cycle the assertions check several properties. A drive must trace back to a read exactly one cycle earlier in flow-through mode, or two cycles earlier in registered mode. A write cycle and a high output enable must keep the drive off. Undriven data must be zero. A deselect with the device unselected must be decoded as such. A strobed start must load the address, a suspend must hold it, and in registered mode the drive must stay on in the cycle after a deselect. What the assertions cannot see is whether the returned data is the right data. The bench scenarios supply that by checking against a reference array. They cover byte-lane merging, the read-only nature of the first strobe, writes that are blocked while unselected, linear and interleaved bursts, suspended bursts, dummy reads that still advance, and the two read latencies.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Width of the burst offset field that the external counter supplies.
    localparam int OFF_W = 2;

    // Kind of access decoded from one sampled cycle.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_DESEL = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } op_e;

    // Sampled strobe and select group.
    typedef struct packed {
        logic sel_n;
        logic sel_hi;
        logic sel_lo_n;
        logic strb_a_n;
        logic strb_b_n;
        logic step_n;
    } ctl_t;

    function automatic logic is_selected(ctl_t c);
        return !c.sel_n && c.sel_hi && !c.sel_lo_n;
    endfunction

    function automatic logic any_strobe(ctl_t c);
        return !c.strb_a_n || !c.strb_b_n;
    endfunction

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              all_wr_n,
    input  logic              byte_wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [OFF_W-1:0]  next_off,
    output op_e               op,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  wr_mask,
    output logic [OFF_W-1:0]  cur_off
);

    logic              act_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  mask;
    logic              strobe;
    logic              selected;

    always_comb begin
        selected = is_selected(ctl);
        strobe   = any_strobe(ctl);
        if (!all_wr_n)
            mask = '1;
        else if (!byte_wr_n)
            mask = ~lane_wr_n;
        else
            mask = '0;

        op       = OP_IDLE;
        acc_addr = addr_q;
        wr_mask  = '0;
        if (strobe) begin
            if (selected) begin
                acc_addr = addr_i;
                if (ctl.strb_a_n && (|mask)) begin
                    op      = OP_WRITE;
                    wr_mask = mask;
                end else begin
                    op = OP_READ;
                end
            end else begin
                op = OP_DESEL;
            end
        end else if (act_q) begin
            if (!ctl.step_n)
                acc_addr = {addr_q[ADDR_W-1:OFF_W], next_off};
            if (|mask) begin
                op      = OP_WRITE;
                wr_mask = mask;
            end else begin
                op = OP_READ;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            if (op == OP_DESEL)
                act_q <= 1'b0;
            else if (strobe)
                act_q <= 1'b1;
            addr_q <= acc_addr;
        end
    end

    assign cur_off = addr_q[OFF_W-1:0];

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        we,
    input  logic                    rd_en,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] q
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] q_l;

        always_ff @(posedge clk) begin
            if (we[l])
                bank[addr] <= wdata[l*LANE_W +: LANE_W];
            if (rd_en)
                q_l <= bank[addr];
        end

        assign q[l*LANE_W +: LANE_W] = q_l;
    end

endmodule

// File: rtl/sbs_outpipe.sv
module sbs_outpipe #(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_issue,
    input  logic              wr_now,
    input  logic [WORD_W-1:0] ram_q,
    input  logic              reg_mode,
    input  logic              oe_n,
    output logic [WORD_W-1:0] data_o,
    output logic              en_o
);

    logic              s1_en;
    logic              s2_en;
    logic [WORD_W-1:0] s2_d;
    logic              stage_en;
    logic [WORD_W-1:0] stage_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_en <= 1'b0;
            s2_en <= 1'b0;
            s2_d  <= '0;
        end else begin
            s1_en <= rd_issue;
            s2_en <= s1_en;
            s2_d  <= ram_q;
        end
    end

    always_comb begin
        stage_en = reg_mode ? s2_en : s1_en;
        stage_d  = reg_mode ? s2_d  : ram_q;
        en_o     = stage_en && !oe_n && !wr_now;
        data_o   = en_o ? stage_d : '0;
    end

endmodule

// File: rtl/sbs_burst_sram.sv
module sbs_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    sel_n_i,
    input  logic                    sel_hi_i,
    input  logic                    sel_lo_n_i,
    input  logic                    strb_a_n_i,
    input  logic                    strb_b_n_i,
    input  logic                    step_n_i,
    input  logic                    all_wr_n_i,
    input  logic                    byte_wr_n_i,
    input  logic [LANES-1:0]        lane_wr_n_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic [OFF_W-1:0]        next_off_i,
    input  logic                    reg_mode_i,
    input  logic                    out_en_n_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    rdata_en_o,
    output logic [OFF_W-1:0]        burst_off_o
);

    localparam int WORD_W = LANES * LANE_W;

    ctl_t              ctl_w;
    op_e               op_w;
    logic [ADDR_W-1:0] acc_addr_w;
    logic [LANES-1:0]  wr_mask_w;
    logic [WORD_W-1:0] ram_q_w;
    logic              rd_issue_w;
    logic              wr_now_w;

    always_comb begin
        ctl_w.sel_n    = sel_n_i;
        ctl_w.sel_hi   = sel_hi_i;
        ctl_w.sel_lo_n = sel_lo_n_i;
        ctl_w.strb_a_n = strb_a_n_i;
        ctl_w.strb_b_n = strb_b_n_i;
        ctl_w.step_n   = step_n_i;
    end

    sbs_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl_w),
        .addr_i    (addr_i),
        .all_wr_n  (all_wr_n_i),
        .byte_wr_n (byte_wr_n_i),
        .lane_wr_n (lane_wr_n_i),
        .next_off  (next_off_i),
        .op        (op_w),
        .acc_addr  (acc_addr_w),
        .wr_mask   (wr_mask_w),
        .cur_off   (burst_off_o)
    );

    assign rd_issue_w = (op_w == OP_READ);
    assign wr_now_w   = (op_w == OP_WRITE);

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk   (clk),
        .addr  (acc_addr_w),
        .we    (wr_mask_w),
        .rd_en (rd_issue_w),
        .wdata (wdata_i),
        .q     (ram_q_w)
    );

    sbs_outpipe #(.WORD_W(WORD_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .rd_issue (rd_issue_w),
        .wr_now   (wr_now_w),
        .ram_q    (ram_q_w),
        .reg_mode (reg_mode_i),
        .oe_n     (out_en_n_i),
        .data_o   (rdata_o),
        .en_o     (rdata_en_o)
    );

endmodule

// File: rtl/sbs_burst_sram_chk.sv
module sbs_burst_sram_chk
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_i,
    input logic              sel_hi_i,
    input logic              strb_a_n_i,
    input logic              strb_b_n_i,
    input logic              step_n_i,
    input logic              reg_mode_i,
    input logic              out_en_n_i,
    input logic [WORD_W-1:0] rdata_o,
    input logic              rdata_en_o,
    input logic [OFF_W-1:0]  burst_off_o,
    input op_e               op
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= 2'd0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R6: a flow-through drive comes from a read one cycle earlier
    p_flow_lat_r6: assert property (@(posedge clk) disable iff (rst)
        (!reg_mode_i && since_rst >= 2'd1 && !$past(reg_mode_i) && rdata_en_o)
            |-> $past(op == OP_READ));

    // R7: a registered drive comes from a read two cycles earlier
    p_pipe_lat_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_mode_i && since_rst >= 2'd2 && $past(reg_mode_i) && $past(reg_mode_i, 2)
            && rdata_en_o) |-> $past(op == OP_READ, 2));

    // R7: in registered mode the drive stays on in the cycle after a deselect
    p_dcd_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_mode_i && since_rst >= 2'd2 && $past(reg_mode_i) && $past(reg_mode_i, 2)
            && $past(op == OP_READ, 2) && $past(op == OP_DESEL)
            && !out_en_n_i && op != OP_WRITE) |-> rdata_en_o);

    // R8: no drive during a write command
    p_write_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE) |-> !rdata_en_o);

    // R9: a high output enable keeps the outputs off
    p_oe_off_r9: assert property (@(posedge clk) disable iff (rst)
        out_en_n_i |-> !rdata_en_o);

    // R11: undriven data reads zero
    p_zero_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !rdata_en_o |-> (rdata_o == '0));

    // R1: a strobe without the high select is a deselect
    p_desel_r1: assert property (@(posedge clk) disable iff (rst)
        (!sel_hi_i && !strb_a_n_i) |-> (op == OP_DESEL));

    // R2: a strobed start loads the external address
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        ((!strb_a_n_i || !strb_b_n_i) && op != OP_DESEL)
            |=> (burst_off_o == $past(addr_i[OFF_W-1:0])));

    // R4: a suspended burst keeps its address
    p_suspend_r4: assert property (@(posedge clk) disable iff (rst)
        (strb_a_n_i && strb_b_n_i && step_n_i && (op == OP_READ || op == OP_WRITE))
            |=> $stable(burst_off_o));

endmodule

bind sbs_burst_sram sbs_burst_sram_chk #(.ADDR_W(ADDR_W), .WORD_W(LANES*LANE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr_i      (addr_i),
    .sel_hi_i    (sel_hi_i),
    .strb_a_n_i  (strb_a_n_i),
    .strb_b_n_i  (strb_b_n_i),
    .step_n_i    (step_n_i),
    .reg_mode_i  (reg_mode_i),
    .out_en_n_i  (out_en_n_i),
    .rdata_o     (rdata_o),
    .rdata_en_o  (rdata_en_o),
    .burst_off_o (burst_off_o),
    .op          (op_w)
);

// File: tb/tb_sbs_burst_sram.sv
module tb_sbs_burst_sram;

    localparam int PER   = 10;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int W     = 36;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          sel_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
    logic          strb_a_n = 1'b1, strb_b_n = 1'b1, step_n = 1'b1;
    logic          all_wr_n = 1'b1, byte_wr_n = 1'b1;
    logic [3:0]    lane_n = 4'hf;
    logic [W-1:0]  wdata = '0;
    logic [1:0]    next_off = 2'd0;
    logic          reg_mode = 1'b0;
    logic          oe_n = 1'b0;
    logic [W-1:0]  rdata;
    logic          rdata_en;
    logic [1:0]    boff;

    sbs_burst_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(9)) dut (
        .clk(clk), .rst(rst), .addr_i(addr), .sel_n_i(sel_n), .sel_hi_i(sel_hi),
        .sel_lo_n_i(sel_lo_n), .strb_a_n_i(strb_a_n), .strb_b_n_i(strb_b_n),
        .step_n_i(step_n), .all_wr_n_i(all_wr_n), .byte_wr_n_i(byte_wr_n),
        .lane_wr_n_i(lane_n), .wdata_i(wdata), .next_off_i(next_off),
        .reg_mode_i(reg_mode), .out_en_n_i(oe_n), .rdata_o(rdata),
        .rdata_en_o(rdata_en), .burst_off_o(boff)
    );

    always #(PER/2) clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string phase  = "R12 reset";

    // Behavioural reference: memory, burst state, two output stages.
    logic [W-1:0] rm [DEPTH];
    int           ma;
    bit           mact;
    bit           e1, e2;
    logic [W-1:0] d1, d2;

    task automatic decode(output bit go, output bit wr, output int a, output logic [3:0] msk);
        bit selv;
        selv = !sel_n && sel_hi && !sel_lo_n;
        msk  = !all_wr_n ? 4'hf : (!byte_wr_n ? ~lane_n : 4'h0);
        go = 0; wr = 0; a = ma;
        if (!strb_a_n || !strb_b_n) begin
            if (selv) begin
                go = 1; a = int'(addr); wr = strb_a_n && (msk != 4'h0);
            end
        end else if (mact) begin
            go = 1;
            if (!step_n) a = (ma & ~3) | int'(next_off);
            wr = (msk != 4'h0);
        end
    endtask

    always @(posedge clk) begin
        bit go, wr; int a; logic [3:0] msk;
        if (rst) begin
            mact = 0; ma = 0; e1 = 0; e2 = 0; d1 = '0; d2 = '0;
        end else begin
            decode(go, wr, a, msk);
            e2 = e1; d2 = d1;
            e1 = go && !wr;
            if (e1) d1 = rm[a];
            if (go && wr)
                for (int l = 0; l < 4; l++)
                    if (msk[l]) rm[a][l*9 +: 9] = wdata[l*9 +: 9];
            if (!strb_a_n || !strb_b_n) mact = go;
            ma = a;
        end
    end

    task automatic compare();
        bit go, wr; int a; logic [3:0] msk;
        bit           en_x;
        logic [W-1:0] d_x;
        decode(go, wr, a, msk);
        en_x = (reg_mode ? e2 : e1) && !oe_n && !(go && wr);
        d_x  = en_x ? (reg_mode ? d2 : d1) : '0;
        checks++;
        if (rdata_en !== en_x) begin
            errors++;
            $display("FAIL %s (R7 enable): got %0b expected %0b", phase, rdata_en, en_x);
        end
        checks++;
        if (rdata !== d_x) begin
            errors++;
            $display("FAIL %s (%s data): got %h expected %h", phase,
                     en_x ? "R6" : "R11", rdata, d_x);
        end
    endtask

    task automatic tick();
        #(PER/4);
        compare();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_off(input logic [1:0] exp);
        checks++;
        if (boff !== exp) begin
            errors++;
            $display("FAIL %s (R4 offset): got %0d expected %0d", phase, boff, exp);
        end
    endtask

    task automatic quiet();
        strb_a_n = 1; strb_b_n = 1; step_n = 1; all_wr_n = 1; byte_wr_n = 1;
        lane_n = 4'hf; sel_n = 0; sel_hi = 1; sel_lo_n = 0;
    endtask

    task automatic desel();
        quiet(); sel_n = 1; strb_b_n = 0; tick(); quiet();
    endtask

    task automatic wr_word(input int a, input logic [W-1:0] d);
        quiet(); strb_b_n = 0; addr = AW'(a); all_wr_n = 0; wdata = d; tick(); quiet();
    endtask

    task automatic rd_word(input int a);
        quiet(); strb_b_n = 0; addr = AW'(a); tick(); quiet();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) rm[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R12: reset state
        phase = "R12 reset";
        chk_off(2'd0);
        tick();

        // R3 R5: full-word writes through the second strobe
        phase = "R3 R5 full writes";
        for (int i = 0; i < 16; i++) wr_word(i, {4'(i), 32'hA5C3_0000 + 32'(i * 4513)});
        desel();

        // R6: flow-through single reads
        phase = "R6 flow single reads";
        reg_mode = 0;
        for (int i = 0; i < 6; i++) rd_word(i);
        desel(); desel();

        // R5: lane-masked write, lanes 0 and 2 written
        phase = "R5 lane write";
        quiet(); strb_b_n = 0; addr = 6'd3; byte_wr_n = 0; lane_n = 4'b1010;
        wdata = 36'h1_2345_6789; tick(); quiet();
        rd_word(3); desel();

        // R2: first strobe with write controls active still reads
        phase = "R2 strobe-a read only";
        quiet(); strb_a_n = 0; addr = 6'd2; all_wr_n = 0; wdata = 36'hF_FFFF_FFFF; tick(); quiet();
        desel(); rd_word(2); desel();

        // R1: unselected strobe writes nothing
        phase = "R1 unselected";
        quiet(); sel_hi = 0; strb_b_n = 0; addr = 6'd1; all_wr_n = 0; wdata = 36'h0_DEAD_BEEF; tick();
        quiet(); sel_lo_n = 1; strb_b_n = 0; addr = 6'd1; all_wr_n = 0; tick(); quiet();
        tick(); rd_word(1); desel(); desel();

        // R6 R7 R4: registered-mode linear burst of four from address 4
        phase = "R6 R7 R4 pipe burst";
        reg_mode = 1;
        quiet(); strb_a_n = 0; addr = 6'd4; tick(); quiet();
        chk_off(2'd0);
        for (int k = 1; k < 4; k++) begin
            step_n = 0; next_off = 2'(k); tick(); chk_off(2'(k));
        end
        quiet();
        desel(); desel(); desel();

        // R4: suspended burst reuses the address
        phase = "R4 suspend";
        quiet(); strb_b_n = 0; addr = 6'd9; tick(); quiet();
        step_n = 1; tick(); chk_off(2'd1);
        step_n = 0; next_off = 2'd2; tick(); chk_off(2'd2);
        quiet(); desel(); desel(); desel();

        // R5 R4: interleaved burst write from address 10 (offsets 2,3,0,1)
        phase = "R5 R4 interleaved write";
        reg_mode = 0;
        quiet(); strb_b_n = 0; addr = 6'd10; all_wr_n = 0; wdata = 36'h7_0000_0010; tick();
        strb_b_n = 1;
        next_off = 2'd3; step_n = 0; wdata = 36'h7_0000_0011; tick(); chk_off(2'd3);
        next_off = 2'd0; wdata = 36'h7_0000_0008; tick(); chk_off(2'd0);
        next_off = 2'd1; wdata = 36'h7_0000_0009; tick(); chk_off(2'd1);
        quiet(); desel();
        for (int i = 8; i < 12; i++) rd_word(i);
        desel();

        // R8: read then write immediately, drive off in the write cycle
        phase = "R8 write kill";
        rd_word(5); wr_word(20, 36'h3_3333_3333); desel(); rd_word(20); desel();

        // R9 R10: dummy read with output enable high still advances
        phase = "R9 R10 dummy read";
        quiet(); oe_n = 1; strb_b_n = 0; addr = 6'd4; tick(); quiet();
        oe_n = 0; step_n = 0; next_off = 2'd1; tick(); chk_off(2'd1);
        oe_n = 1; next_off = 2'd2; tick();
        oe_n = 0; quiet(); desel(); desel();

        // R7: registered-mode deselect holds drive one more cycle
        phase = "R7 dcd hold";
        reg_mode = 1;
        rd_word(6); desel(); desel(); desel();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule